// File: doc/BRIEF.md
# Hiccup Overcurrent Fault Counter

This block supervises overcurrent in a synchronous buck converter, one switching cycle at a time. Two comparator flags come in, one for each power FET. A strobe marks the last clock of every switching cycle. The block also receives the high-side and low-side on-commands from the PWM stage and passes them on as gate enables.

A comparator flag counts only while its own FET is commanded on. If any qualified flag is seen during a cycle, a small saturating counter steps up at the end of that cycle. A clean cycle steps the counter down. A high-side flag also cuts the high-side enable for the rest of that cycle, whatever the counter holds.

When the counter reaches its fault limit, the block enters a hiccup period. Both gate enables are held off and all comparator flags are ignored. A timer counts a programmed number of switching cycles. When the timer expires, the block clears the counter and issues a one-clock restart pulse, which can retrigger soft-start. Switching then resumes. If the short is still present, the same loop of fault, wait and restart repeats with no limit.

Top module: `hiccup_ocp_supervisor`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `oc_count` is 0, `fault` and `restart_pulse` are 0, and both gate enables are 0 until an on-command is given.
- R2: `hs_oc` is qualified only on clocks where `hs_on` is 1, and `ls_oc` only on clocks where `ls_on` is 1. A flag raised while its FET is off changes neither the count nor the gates.
- R3: In the running state, if a qualified flag was seen on any clock of a switching cycle (the clocks up to and including the one where `cyc_end` is 1), `oc_count` rises by exactly one at the edge that samples `cyc_end`. The count saturates at its maximum.
- R4: In the running state, a switching cycle with no qualified flag lowers `oc_count` by exactly one at its `cyc_end` edge. The count never goes below 0.
- R5: `hs_gate_en` is a registered copy of `hs_on`, with a latency of one clock. Starting at the edge that samples a qualified `hs_oc`, it is 0 for the rest of that switching cycle. This happens at any count value.
- R6: While running, `ls_gate_en` is `ls_on` delayed by one clock.
- R7: At the `cyc_end` edge where `oc_count` becomes `FAULT_LIMIT` (7 by default), `fault` goes to 1 and both gate enables go to 0.
- R8: During a fault, the `TIMEOUT_CYC`-th `cyc_end` edge after the fault was entered does three things: it clears `fault`, sets `oc_count` to 0, and raises `restart_pulse` for exactly one clock. Switching resumes from that edge.
- R9: While `fault` is 1, both comparator flags are ignored. `oc_count` holds, and no flag from this period carries into the first cycle after the restart.
- R10: A short that persists after a restart raises the fault again after `FAULT_LIMIT` cycles, and the fault, wait and restart loop repeats for as long as the short persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_end | input | 1 | High on the last clock of each switching cycle |
| hs_on | input | 1 | High-side on-command from the PWM stage |
| ls_on | input | 1 | Low-side on-command from the PWM stage |
| hs_oc | input | 1 | High-side overcurrent comparator flag |
| ls_oc | input | 1 | Low-side overcurrent comparator flag |
| hs_gate_en | output | 1 | Registered high-side gate enable |
| ls_gate_en | output | 1 | Registered low-side gate enable |
| fault | output | 1 | High from fault declaration until restart |
| restart_pulse | output | 1 | One-clock pulse at the restart |
| oc_count | output | CNT_W | Current value of the fault counter |

## Verification
The counter is itself an output, so a wrong count step appears on `oc_count` one clock after the `cyc_end` edge that caused it. A count that leaks during the hiccup, or a flag that carries over it, shows as a nonzero count after the first clean cycle that follows the restart. An error in the early turn-off or in the gate masking shows on the gate enables within one clock. A timer that is off by one moves the restart pulse by a whole switching cycle.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic {
    ST_RUN    = 1'b0,
    ST_HICCUP = 1'b1
  } ocp_state_t;
endpackage

// File: rtl/ocp_cycle_sense.sv
module ocp_cycle_sense (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic cyc_end,
  input  logic hs_on,
  input  logic ls_on,
  input  logic hs_oc,
  input  logic ls_oc,
  output logic cyc_hit,
  output logic hs_hit_now,
  output logic hs_trip
);
  logic hit_sticky;
  logic ls_hit_now;

  assign hs_hit_now = arm & hs_on & hs_oc;
  assign ls_hit_now = arm & ls_on & ls_oc;
  assign cyc_hit    = hit_sticky | hs_hit_now | ls_hit_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_sticky <= 1'b0;
      hs_trip    <= 1'b0;
    end else if (cyc_end || !arm) begin
      hit_sticky <= 1'b0;
      hs_trip    <= 1'b0;
    end else begin
      hit_sticky <= cyc_hit;
      hs_trip    <= hs_trip | hs_hit_now;
    end
  end

  AST_STICKY_CLEARED_OFF: assert property (@(posedge clk) disable iff (rst)
    !arm |=> !hit_sticky && !hs_trip); // R9
  AST_TRIP_HELD_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (hs_trip && !cyc_end && arm) |=> hs_trip); // R5
endmodule

// File: rtl/ocp_fault_counter.sv
module ocp_fault_counter #(
  parameter int CNT_W       = 3,
  parameter int FAULT_LIMIT = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             up,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             at_limit
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM_V   = CNT_W'(FAULT_LIMIT);

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (up) begin
      if (cnt != CNT_MAX) cnt_nxt = cnt + 1'b1;
    end else begin
      if (cnt != '0) cnt_nxt = cnt - 1'b1;
    end
  end

  assign at_limit = step && up && (cnt_nxt == LIM_V);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= cnt_nxt;
  end

  AST_CNT_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(clr) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 ||
                     cnt == $past(cnt) - 1'b1)); // R3
  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt) == '0 && !$past(up)) |-> cnt == '0); // R4
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt) == CNT_MAX && !$past(clr)) |-> cnt == CNT_MAX); // R3
endmodule

// File: rtl/ocp_hiccup_timer.sv
module ocp_hiccup_timer #(
  parameter int TIMEOUT_CYC = 12000
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic tick,
  output logic done
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);

  logic [TW-1:0] tmr;

  assign done = active && tick && (tmr == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active || done) tmr <= '0;
    else if (tick)              tmr <= tmr + 1'b1;
  end

  AST_TMR_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    tmr < TW'(TIMEOUT_CYC)); // R8
  AST_TMR_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(active) |-> tmr == '0); // R8
endmodule

// File: rtl/hiccup_ocp_supervisor.sv
module hiccup_ocp_supervisor
  import ocp_pkg::*;
#(
  parameter int CNT_W       = 3,
  parameter int FAULT_LIMIT = 7,
  parameter int TIMEOUT_CYC = 12000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_end,
  input  logic             hs_on,
  input  logic             ls_on,
  input  logic             hs_oc,
  input  logic             ls_oc,
  output logic             hs_gate_en,
  output logic             ls_gate_en,
  output logic             fault,
  output logic             restart_pulse,
  output logic [CNT_W-1:0] oc_count
);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(FAULT_LIMIT);

  ocp_state_t state, state_nxt;
  logic running, run_nxt;
  logic cyc_hit, hs_hit_now, hs_trip;
  logic at_limit, tmr_done, restart;

  assign running = (state == ST_RUN);

  ocp_cycle_sense u_sense (
    .clk        (clk),
    .rst        (rst),
    .arm        (running),
    .cyc_end    (cyc_end),
    .hs_on      (hs_on),
    .ls_on      (ls_on),
    .hs_oc      (hs_oc),
    .ls_oc      (ls_oc),
    .cyc_hit    (cyc_hit),
    .hs_hit_now (hs_hit_now),
    .hs_trip    (hs_trip)
  );

  ocp_fault_counter #(.CNT_W(CNT_W), .FAULT_LIMIT(FAULT_LIMIT)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step     (cyc_end && running),
    .up       (cyc_hit),
    .clr      (restart),
    .cnt      (oc_count),
    .at_limit (at_limit)
  );

  ocp_hiccup_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .active (!running),
    .tick   (cyc_end),
    .done   (tmr_done)
  );

  assign restart = !running && tmr_done;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_RUN:    if (at_limit) state_nxt = ST_HICCUP;
      ST_HICCUP: if (tmr_done) state_nxt = ST_RUN;
      default:   state_nxt = ST_RUN;
    endcase
  end

  assign run_nxt = (state_nxt == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_RUN;
      fault         <= 1'b0;
      restart_pulse <= 1'b0;
      hs_gate_en    <= 1'b0;
      ls_gate_en    <= 1'b0;
    end else begin
      state         <= state_nxt;
      fault         <= !run_nxt;
      restart_pulse <= restart;
      hs_gate_en    <= run_nxt && hs_on && !hs_hit_now && !hs_trip;
      ls_gate_en    <= run_nxt && ls_on;
    end
  end

  AST_FAULT_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
    fault |-> !hs_gate_en && !ls_gate_en); // R7
  AST_FAULT_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> oc_count == LIM_V); // R7
  AST_RESTART_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    restart_pulse |=> !restart_pulse); // R8
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart_pulse |-> (oc_count == '0) && !fault && $fell(fault)); // R8
  AST_FAULT_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
    (fault && $past(fault)) |-> oc_count == $past(oc_count)); // R9
  AST_HS_CUT_ON_OC: assert property (@(posedge clk) disable iff (rst)
    $past(hs_on && hs_oc) |-> !hs_gate_en); // R5
endmodule

// File: tb/hiccup_ocp_supervisor_bench.sv
module hiccup_ocp_supervisor_bench;
  localparam int TO  = 4;
  localparam int LIM = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_end = 1'b0, hs_on = 1'b0, ls_on = 1'b0, hs_oc = 1'b0, ls_oc = 1'b0;
  logic hs_gate_en, ls_gate_en, fault, restart_pulse;
  logic [2:0] oc_count;

  always #10 clk = ~clk;

  hiccup_ocp_supervisor #(.CNT_W(3), .FAULT_LIMIT(LIM), .TIMEOUT_CYC(TO)) u_hiccup_ocp_supervisor (
    .clk(clk), .rst(rst), .cyc_end(cyc_end), .hs_on(hs_on), .ls_on(ls_on),
    .hs_oc(hs_oc), .ls_oc(ls_oc), .hs_gate_en(hs_gate_en), .ls_gate_en(ls_gate_en),
    .fault(fault), .restart_pulse(restart_pulse), .oc_count(oc_count)
  );

  typedef struct {
    int    cnt;
    bit    flt;
    bit    rsp;
    string req;
  } exp_t;

  exp_t sbq[$];
  int total = 0;
  int bad = 0;
  int m_cnt = 0, m_tmr = 0;
  bit m_flt = 1'b0;
  logic end_seen = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) end_seen <= cyc_end;

  // monitor: compares results one clock after each cycle end
  always @(negedge clk) begin
    if (!rst) begin
      if (end_seen) begin
        if (sbq.size() == 0) begin
          check("R3", "scoreboard empty", 0, 1);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(e.req, "oc_count", int'(oc_count), e.cnt);
          check(e.req, "fault", int'(fault), int'(e.flt));
          check(e.req, "restart_pulse", int'(restart_pulse), int'(e.rsp));
        end
      end else if (restart_pulse) begin
        check("R8", "restart_pulse off-edge", 1, 0);
      end
    end
  end

  // one switching cycle: high side for hs_len clocks, low side for ls_len clocks
  task automatic sw_cycle(input int hs_len, input int ls_len, input int hs_at,
                          input int ls_at, input bit ghost, input string req);
    int len;
    bit hit;
    bit run_now;
    bit rsp;
    len = hs_len + ls_len;
    hit = (hs_at >= 0) || (ls_at >= 0);
    for (int k = 0; k < len; k++) begin
      bit hph, exp_hs, exp_ls, run_after;
      exp_t e;
      hph = (k < hs_len);
      hs_on   = hph;
      ls_on   = !hph;
      hs_oc   = (hph && k == hs_at) || (ghost && !hph);
      ls_oc   = (!hph && (k - hs_len) == ls_at) || (ghost && hph);
      cyc_end = (k == len - 1);
      run_now = !m_flt;
      run_after = run_now;
      if (cyc_end) begin
        rsp = 1'b0;
        if (!m_flt) begin
          if (hit) m_cnt = (m_cnt < 7) ? m_cnt + 1 : 7;
          else     m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
          if (m_cnt == LIM) begin m_flt = 1'b1; m_tmr = 0; end
        end else begin
          m_tmr++;
          if (m_tmr == TO) begin m_flt = 1'b0; m_cnt = 0; m_tmr = 0; rsp = 1'b1; end
        end
        run_after = !m_flt;
        e.cnt = m_cnt; e.flt = m_flt; e.rsp = rsp; e.req = req;
        sbq.push_back(e);
      end
      exp_hs = run_after && hph && !(hs_at >= 0 && k >= hs_at && run_now);
      exp_ls = run_after && !hph;
      @(negedge clk);
      check(m_flt ? "R7" : "R5", "hs_gate_en", int'(hs_gate_en), int'(exp_hs));
      check(m_flt ? "R7" : "R6", "ls_gate_en", int'(ls_gate_en), int'(exp_ls));
    end
    hs_on = 0; ls_on = 0; hs_oc = 0; ls_oc = 0; cyc_end = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset oc_count", int'(oc_count), 0);
    check("R1", "reset fault", int'(fault), 0);
    check("R1", "reset gates", int'(hs_gate_en | ls_gate_en), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "post-reset restart_pulse", int'(restart_pulse), 0);
    // R4: clean cycles keep count at zero
    sw_cycle(3, 3, -1, -1, 1'b0, "R4");
    // R2: flags while the FET is off are ignored
    sw_cycle(3, 3, -1, -1, 1'b1, "R2");
    sw_cycle(2, 4, -1, -1, 1'b1, "R2");
    // R3 and R5: high-side hits, early cut
    sw_cycle(4, 3, 1, -1, 1'b0, "R3");
    sw_cycle(4, 3, 0, -1, 1'b0, "R5");
    // R3: low-side hit, last clock of cycle
    sw_cycle(3, 3, -1, 2, 1'b0, "R3");
    // R4: decrement
    sw_cycle(3, 3, -1, -1, 1'b0, "R4");
    sw_cycle(3, 3, -1, -1, 1'b0, "R4");
    // R7: climb to limit
    for (int i = 0; i < 6; i++) sw_cycle(3, 3, 2, 0, 1'b0, "R7");
    // R9: hits during hiccup ignored; R8 restart
    for (int i = 0; i < TO; i++) sw_cycle(3, 3, 1, 1, 1'b0, (i == TO - 1) ? "R8" : "R9");
    sw_cycle(3, 3, -1, -1, 1'b0, "R9");
    // R10: persistent short, two hiccup loops
    for (int j = 0; j < 2; j++) begin
      for (int i = 0; i < LIM + TO; i++) sw_cycle(2, 2, 0, -1, 1'b0, "R10");
    end
    sw_cycle(3, 3, -1, -1, 1'b0, "R10");
    repeat (2) @(negedge clk);
    check("R3", "scoreboard drained", sbq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL R1 watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule